// File: doc/BRIEF.md
# Mode-Configurable Timer/Counter with Capture

This block is a pair of counter halves that a two-bit mode field rearranges at run time. The halves can run as two separate 8-bit timers. They can run as an 8-bit timer beside an 8-bit event counter. They can also be chained into one 16-bit timer or one 16-bit event counter. Timer ticks come from a single shared programmable prescaler. Event ticks come from an external pin, which is synchronized and edge-detected before use. When a counter passes its match value it wraps to zero and pulses a flag.

Two strobe pins copy the live count into a capture register. In the split modes each strobe owns one 8-bit half. In the joined modes the low strobe takes the whole 16-bit count and the high strobe is ignored. Software programs the block through a small write port: a control word that holds the run bit and the mode, a prescaler reload value and two match values. Writing the control word restarts the counters from zero.

Top module: `tcap_unit`

## Requirements
- R1: After reset both counters, both capture halves and both flags are zero, and the run bit is clear.
- R2: With run set and `cnt_en` high, the prescaler issues one timer tick every reload+1 enabled cycles. The reload value is written at address 1.
- R3: In mode 0 (control bits [2:1] = 0), each half counts prescaler ticks on its own. A half whose count equals its match value (address 2 for low, address 3 for high) returns to zero on its next tick. That wrap raises its flag (`flag_lo` or `flag_hi`) for exactly one cycle.
- R4: In mode 1, the low half counts prescaler ticks and the high half counts synchronized event edges. When both kinds of tick arrive in the same cycle, both halves advance.
- R5: In mode 2, the halves form one 16-bit timer that counts prescaler ticks, with the carry passing from low to high. It wraps to zero on the tick after the count equals {match high, match low}. Only `flag_hi` pulses, and `flag_lo` stays low.
- R6: In mode 3, the 16-bit counter counts synchronized event edges and uses the same wrap and flag rules as R5.
- R7: `evt_in` passes through two synchronizing flip-flops and counts once per rising edge, however long it stays high.
- R8: In modes 0 and 1, a rising edge on `cap_lo_in` copies the low count into `cap_q[7:0]`. A rising edge on `cap_hi_in` copies the high count into `cap_q[15:8]`. Each strobe leaves the other half untouched.
- R9: In modes 2 and 3, a rising edge on `cap_lo_in` copies the full 16-bit count into `cap_q`, and `cap_hi_in` has no effect.
- R10: The counters and the prescaler advance only while the run bit (control bit 0) and `cnt_en` are both high. Otherwise they hold their values.
- R11: A write to the control word (address 0) clears both counters and both flags in the same edge and restarts the prescaler from its reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable for prescaler and counters |
| evt_in | input | 1 | External event input (asynchronous) |
| cap_lo_in | input | 1 | Low-half capture strobe (asynchronous) |
| cap_hi_in | input | 1 | High-half capture strobe (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 reload, 2 match low, 3 match high |
| wr_data | input | 8 | Register write data; control uses bit 0 run and bits 2:1 mode |
| flag_lo | output | 1 | One-cycle pulse on a low-half wrap |
| flag_hi | output | 1 | One-cycle pulse on a high-half or 16-bit wrap |
| cap_q | output | 16 | Capture register contents, high half in the upper byte |

## Verification
In mode 1, a prescaler underflow and a synchronized event edge can reach the two halves on the same clock edge. The bench sets the reload to 2 and gives the events a period of four cycles, so the two kinds of tick meet every twelve cycles. After a fixed window it freezes the counters and captures both halves. The result must equal the number of timer ticks in the low byte and the number of events in the high byte, and a tick lost at a collision would show as a short count. A further property checks that a control-word write landing on a counting edge always leaves the counter at zero.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    MD_DUAL_TMR  = 2'd0,
    MD_TMR_EVT   = 2'd1,
    MD_WIDE_TMR  = 2'd2,
    MD_WIDE_EVT  = 2'd3
  } tcap_mode_e;

  localparam logic [1:0] ADR_CTRL   = 2'd0;
  localparam logic [1:0] ADR_RELOAD = 2'd1;
  localparam logic [1:0] ADR_MLO    = 2'd2;
  localparam logic [1:0] ADR_MHI    = 2'd3;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_MODE_LSB = 1;

endpackage

// File: rtl/tcap_cfg.sv
module tcap_cfg import tcap_pkg::*; #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  output logic              run,
  output tcap_mode_e        mode,
  output logic [HALF_W-1:0] reload,
  output logic [HALF_W-1:0] match_lo,
  output logic [HALF_W-1:0] match_hi,
  output logic              ctrl_wr
);

  logic              run_d, run_q;
  tcap_mode_e        mode_d, mode_q;
  logic [HALF_W-1:0] rel_d, rel_q;
  logic [HALF_W-1:0] mlo_d, mlo_q;
  logic [HALF_W-1:0] mhi_d, mhi_q;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    rel_d  = rel_q;
    mlo_d  = mlo_q;
    mhi_d  = mhi_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADR_CTRL: begin
          run_d  = wr_data[CTRL_RUN_BIT];
          mode_d = tcap_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
        end
        ADR_RELOAD: rel_d = wr_data;
        ADR_MLO:    mlo_d = wr_data;
        default:    mhi_d = wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MD_DUAL_TMR;
      rel_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
    end else if (wr_en) begin
      run_q  <= run_d;
      mode_q <= mode_d;
      rel_q  <= rel_d;
      mlo_q  <= mlo_d;
      mhi_q  <= mhi_d;
    end
  end

  assign run      = run_q;
  assign mode     = mode_q;
  assign reload   = rel_q;
  assign match_lo = mlo_q;
  assign match_hi = mhi_q;

endmodule

// File: rtl/tcap_edge.sv
module tcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] sh_d, sh_q;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/tcap_prescale.sv
module tcap_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             restart,
  input  logic [PRE_W-1:0] reload,
  output logic             tick
);

  logic [PRE_W-1:0] pre_d, pre_q;

  always_comb begin
    tick  = adv && (pre_q == '0);
    pre_d = pre_q;
    if (restart)   pre_d = reload;
    else if (tick) pre_d = reload;
    else if (adv)  pre_d = pre_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/tcap_count.sv
module tcap_count import tcap_pkg::*; #(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tcap_mode_e          mode,
  input  logic                adv,
  input  logic                clr,
  input  logic                pre_tick,
  input  logic                evt_tick,
  input  logic [HALF_W-1:0]   match_lo,
  input  logic [HALF_W-1:0]   match_hi,
  output logic [2*HALF_W-1:0] cnt,
  output logic                flag_lo,
  output logic                flag_hi
);

  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_d, lo_q, hi_d, hi_q;
  logic              flo_d, flo_q, fhi_d, fhi_q;
  logic              joined, lo_evt_src, hi_evt_src;
  logic              tick_lo, tick_hi;
  logic              lo_hit, hi_hit;
  logic [FULL_W-1:0] wide_inc;

  assign joined     = mode[1];
  assign lo_evt_src = (mode == MD_WIDE_EVT);
  assign hi_evt_src = (mode == MD_WIDE_EVT) || (mode == MD_TMR_EVT);
  assign tick_lo    = adv && (lo_evt_src ? evt_tick : pre_tick);
  assign tick_hi    = adv && (hi_evt_src ? evt_tick : pre_tick);
  assign lo_hit     = (lo_q == match_lo);
  assign hi_hit     = (hi_q == match_hi);
  assign wide_inc   = {hi_q, lo_q} + 1'b1;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    flo_d = 1'b0;
    fhi_d = 1'b0;
    if (clr) begin
      lo_d = '0;
      hi_d = '0;
    end else if (joined) begin
      if (tick_lo) begin
        if (lo_hit && hi_hit) begin
          lo_d  = '0;
          hi_d  = '0;
          fhi_d = 1'b1;
        end else begin
          {hi_d, lo_d} = wide_inc;
        end
      end
    end else begin
      if (tick_lo) begin
        lo_d  = lo_hit ? '0 : lo_q + 1'b1;
        flo_d = lo_hit;
      end
      if (tick_hi) begin
        hi_d  = hi_hit ? '0 : hi_q + 1'b1;
        fhi_d = hi_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      flo_q <= 1'b0;
      fhi_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      flo_q <= flo_d;
      fhi_q <= fhi_d;
    end
  end

  assign cnt     = {hi_q, lo_q};
  assign flag_lo = flo_q;
  assign flag_hi = fhi_q;

endmodule

// File: rtl/tcap_capture.sv
module tcap_capture #(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                joined,
  input  logic                stb_lo,
  input  logic                stb_hi,
  input  logic [2*HALF_W-1:0] cnt,
  output logic [2*HALF_W-1:0] cap
);

  logic [HALF_W-1:0] clo_d, clo_q, chi_d, chi_q;
  logic              take_lo, take_hi;

  assign take_lo = stb_lo;
  assign take_hi = joined ? stb_lo : stb_hi;

  always_comb begin
    clo_d = clo_q;
    chi_d = chi_q;
    if (take_lo) clo_d = cnt[HALF_W-1:0];
    if (take_hi) chi_d = cnt[2*HALF_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clo_q <= '0;
      chi_q <= '0;
    end else begin
      if (take_lo) clo_q <= clo_d;
      if (take_hi) chi_q <= chi_d;
    end
  end

  assign cap = {chi_q, clo_q};

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit import tcap_pkg::*; #(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic                evt_in,
  input  logic                cap_lo_in,
  input  logic                cap_hi_in,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [HALF_W-1:0]   wr_data,
  output logic                flag_lo,
  output logic                flag_hi,
  output logic [2*HALF_W-1:0] cap_q
);

  localparam int FULL_W = 2 * HALF_W;
  localparam int N_PINS = 3;
  localparam int PIN_EVT = 0;
  localparam int PIN_CLO = 1;
  localparam int PIN_CHI = 2;

  logic              run_w, clr_w, adv_w, restart_w, pre_tick_w;
  tcap_mode_e        mode_w;
  logic [HALF_W-1:0] reload_w, mlo_w, mhi_w;
  logic [FULL_W-1:0] cnt_w;
  logic [N_PINS-1:0] pin_vec, rise_vec;
  logic              evt_rise_w, stb_lo_w, stb_hi_w;

  tcap_cfg #(.HALF_W(HALF_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .run      (run_w),
    .mode     (mode_w),
    .reload   (reload_w),
    .match_lo (mlo_w),
    .match_hi (mhi_w),
    .ctrl_wr  (clr_w)
  );

  assign pin_vec[PIN_EVT] = evt_in;
  assign pin_vec[PIN_CLO] = cap_lo_in;
  assign pin_vec[PIN_CHI] = cap_hi_in;

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    tcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_vec[g]),
      .rise  (rise_vec[g])
    );
  end

  assign evt_rise_w = rise_vec[PIN_EVT];
  assign stb_lo_w   = rise_vec[PIN_CLO];
  assign stb_hi_w   = rise_vec[PIN_CHI];

  assign adv_w     = run_w && cnt_en;
  assign restart_w = clr_w || !run_w;

  tcap_prescale #(.PRE_W(HALF_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv_w),
    .restart (restart_w),
    .reload  (reload_w),
    .tick    (pre_tick_w)
  );

  tcap_count #(.HALF_W(HALF_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_w),
    .adv      (adv_w),
    .clr      (clr_w),
    .pre_tick (pre_tick_w),
    .evt_tick (evt_rise_w),
    .match_lo (mlo_w),
    .match_hi (mhi_w),
    .cnt      (cnt_w),
    .flag_lo  (flag_lo),
    .flag_hi  (flag_hi)
  );

  tcap_capture #(.HALF_W(HALF_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .joined (mode_w[1]),
    .stb_lo (stb_lo_w),
    .stb_hi (stb_hi_w),
    .cnt    (cnt_w),
    .cap    (cap_q)
  );

endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk import tcap_pkg::*; #(
  parameter int HALF_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnt_en,
  input logic                wr_en,
  input logic [1:0]          wr_addr,
  input logic                flag_lo,
  input logic                flag_hi,
  input logic [2*HALF_W-1:0] cap_q,
  input logic [2*HALF_W-1:0] cnt,
  input logic [1:0]          mode,
  input logic                evt_rise,
  input logic                stb_lo
);

  localparam int FULL_W = 2 * HALF_W;

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_addr == ADR_CTRL);

  AST_LO_FLAG_SPLIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> !flag_lo); // R5

  AST_WIDE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && mode[1]) |-> (cnt == '0)); // R6

  AST_SPLIT_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flag_lo |-> (cnt[HALF_W-1:0] == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ctrl_hit) |=> $stable(cnt)); // R10

  AST_CAP_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_lo |=> $stable(cap_q[HALF_W-1:0])); // R8

  AST_CAP_HI_JOINED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !stb_lo) |=> $stable(cap_q[FULL_W-1:HALF_W])); // R9

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rise |=> !evt_rise); // R7

  AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> ((cnt == '0) && !flag_lo && !flag_hi)); // R11

endmodule

bind tcap_unit tcap_unit_chk #(.HALF_W(HALF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .flag_lo  (flag_lo),
  .flag_hi  (flag_hi),
  .cap_q    (cap_q),
  .cnt      (cnt_w),
  .mode     (mode_w),
  .evt_rise (evt_rise_w),
  .stb_lo   (stb_lo_w)
);

// File: tb/sim_tcap_unit.sv
module sim_tcap_unit;

  localparam int CLK_NS = 20;

  logic        clk;
  logic        rst_n;
  logic        cnt_en, evt_in, cap_lo_in, cap_hi_in, wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        flag_lo, flag_hi;
  logic [15:0] cap_q;

  int n_checks = 0;
  int n_errors = 0;
  int n_flo = 0;
  int n_fhi = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] val;
    int          req;
  } exp_t;
  exp_t sb_q[$];

  tcap_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .evt_in    (evt_in),
    .cap_lo_in (cap_lo_in),
    .cap_hi_in (cap_hi_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flag_lo   (flag_lo),
    .flag_hi   (flag_hi),
    .cap_q     (cap_q)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && flag_lo) n_flo++;
    if (rst_n && flag_hi) n_fhi++;
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares the capture register once the strobe has landed
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      repeat (5) @(negedge clk);
      begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, {16'h0, cap_q}, {16'h0, e.val});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // control word: bit0 run, bits 2:1 mode
  task automatic ctrl(input logic [1:0] md, input logic rn);
    wr(2'd0, {5'b0, md, rn});
  endtask

  task automatic window(input int k, input int npulse);
    @(negedge clk);
    cnt_en = 1'b1;
    fork
      begin
        repeat (k) @(posedge clk);
        @(negedge clk);
        cnt_en = 1'b0;
      end
      begin
        for (int i = 0; i < npulse; i++) begin
          evt_in = 1'b1;
          repeat (2) @(negedge clk);
          evt_in = 1'b0;
          repeat (2) @(negedge clk);
        end
      end
    join
    repeat (2) @(negedge clk);
  endtask

  // driver: push the expected capture, then fire the chosen strobe
  task automatic cap_expect(input bit hi, input logic [15:0] v, input int req);
    exp_t e;
    e.val = v;
    e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    if (hi) cap_hi_in = 1'b1; else cap_lo_in = 1'b1;
    repeat (2) @(negedge clk);
    cap_hi_in = 1'b0;
    cap_lo_in = 1'b0;
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk);
    n_flo = 0;
    n_fhi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; evt_in = 1'b0;
    cap_lo_in = 1'b0; cap_hi_in = 1'b0;
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, {16'h0, cap_q}, 32'h0);
    check(1, {31'h0, flag_lo}, 32'h0);
    check(1, {31'h0, flag_hi}, 32'h0);

    // R3 mode 0 split wrap: reload 0, match lo 4, match hi 9, 33 ticks
    wr(2'd1, 8'd0); wr(2'd2, 8'd4); wr(2'd3, 8'd9);
    ctrl(2'd0, 1'b1);
    clr_flags();
    window(33, 0);
    check(3, n_flo, 6);   // R3 low flag count
    check(3, n_fhi, 3);   // R3 high flag count
    cap_expect(1'b0, 16'h0003, 8);  // R8 low strobe only low byte
    cap_expect(1'b1, 16'h0303, 8);  // R8 high strobe only high byte

    // R10 idle with cnt_en low holds count
    repeat (20) @(negedge clk);
    cap_expect(1'b0, 16'h0303, 10);

    // R10 run clear: cnt_en high does nothing
    ctrl(2'd0, 1'b0);
    window(20, 0);
    cap_expect(1'b0, 16'h0300, 10);

    // R2 prescaler period: reload 4 -> tick every 5 cycles, 23 cycles -> 4 ticks
    wr(2'd1, 8'd4); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    ctrl(2'd0, 1'b1);
    window(23, 0);
    cap_expect(1'b0, 16'h0304, 2);
    cap_expect(1'b1, 16'h0404, 2);

    // R4 mode 1: reload 2 (ticks every 3), 10 events in 44 cycles, ticks coincide
    wr(2'd1, 8'd2);
    ctrl(2'd1, 1'b1);
    window(44, 10);
    cap_expect(1'b0, 16'h040E, 4);
    cap_expect(1'b1, 16'h0A0E, 4);  // R7 ten pulses, ten counts

    // R5 mode 2: 16-bit, match 0x0102, 300 ticks -> one wrap, count 41
    wr(2'd2, 8'h02); wr(2'd3, 8'h01);
    ctrl(2'd2, 1'b1);
    clr_flags();
    window(900, 0);
    check(5, n_fhi, 1);
    check(5, n_flo, 0);
    cap_expect(1'b0, 16'h0029, 5);
    window(30, 0);
    cap_expect(1'b1, 16'h0029, 9);  // R9 high strobe ignored in joined mode
    cap_expect(1'b0, 16'h0033, 9);

    // R6 mode 3: 16-bit events, match 7, 20 events -> two wraps, count 4
    wr(2'd2, 8'd7); wr(2'd3, 8'd0);
    ctrl(2'd3, 1'b1);
    clr_flags();
    window(84, 20);
    check(6, n_fhi, 2);
    check(6, n_flo, 0);
    cap_expect(1'b0, 16'h0004, 6);

    // R7 a long high level counts once
    @(negedge clk);
    cnt_en = 1'b1; evt_in = 1'b1;
    repeat (10) @(negedge clk);
    evt_in = 1'b0;
    repeat (4) @(negedge clk);
    cnt_en = 1'b0;
    cap_expect(1'b0, 16'h0005, 7);

    // R11 control write clears the counter
    ctrl(2'd3, 1'b1);
    cap_expect(1'b0, 16'h0000, 11);
    check(11, {30'h0, flag_hi, flag_lo}, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule